// File: doc/BRIEF.md
# CAN Controller Mode Acknowledge Unit

This unit sits between the software-visible control bits of a CAN controller and its protocol engine. It receives a request to enter initialization and a request to enter low-power sleep, and answers each with a hardware acknowledge flag. The flags are set only once the controller has actually reached the mode. Software polls the flags to learn when a mode change has taken effect.

Leaving initialization is not immediate. Once the initialization request drops, the unit enters a synchronization wait. It counts bit-time strobes on which the sampled receive line is recessive. After eleven in a row it reports the controller as synchronized to the bus and drops the initialization acknowledge. Leaving sleep also passes through the same synchronization wait. A separate registered path raises an interrupt request from an error-status flag, gated by an enable.

Top module: `can_mode_ack_ctrl`

## Requirements
- R1: While the initialization request is high, the mode moves to INIT at the next clock edge and the initialization acknowledge is high from that edge on.
- R2: The mode output uses the encoding RESET_INIT=0, INIT=1, SYNC_WAIT=2, NORMAL=3, SLEEP=4. During reset the mode is RESET_INIT, the initialization acknowledge is 1, the sleep acknowledge is 0 and the synchronized flag is 0. At the first edge after reset the mode becomes INIT.
- R3: The recessive-run counter advances only on bit strobes sampled while the mode is SYNC_WAIT with the receive line at 1 (recessive). A strobe with the receive line at 0 (dominant) restarts the count at zero. Strobes in any other mode have no effect. The count saturates at 11.
- R4: At the edge after the eleventh consecutive recessive strobe, the mode becomes NORMAL. At that edge the synchronized flag rises and the initialization acknowledge falls. The synchronized flag is high exactly while the mode is NORMAL.
- R5: In INIT with the initialization request low, and in SYNC_WAIT or NORMAL, a high sleep request moves the mode to SLEEP at the next edge and sets the sleep acknowledge. Dropping the sleep request moves the mode from SLEEP to SYNC_WAIT, which clears the sleep acknowledge, and the initialization acknowledge stays 0.
- R6: The interrupt request equals, one clock later, the error-status flag ANDed with the error interrupt enable. With the enable low it stays 0.
- R7: When both requests are high, the initialization request wins: the next mode is INIT and the sleep acknowledge is 0.
- R8: The two acknowledge flags are registered outputs and are never high in the same cycle.
- R9: In INIT with both requests low, the mode moves to SYNC_WAIT at the next edge. The initialization acknowledge stays high there until NORMAL is reached, or until a request moves the mode elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req_i | input | 1 | Software request for initialization mode |
| sleep_req_i | input | 1 | Software request for sleep mode |
| rx_i | input | 1 | Sampled receive line, 1 = recessive |
| bit_tick_i | input | 1 | One-cycle strobe per nominal bit time |
| err_flag_i | input | 1 | Error-status change flag |
| err_irq_en_i | input | 1 | Error interrupt enable |
| init_ack_o | output | 1 | Initialization acknowledge |
| sleep_ack_o | output | 1 | Sleep acknowledge |
| synced_o | output | 1 | Controller synchronized to the bus (NORMAL) |
| mode_o | output | 3 | Current mode, encoding given in R2 |
| irq_o | output | 1 | Error/status-change interrupt request |

## Verification
The assertions watch, on every cycle, the properties that hold for any input sequence. These are the exclusivity of the two acknowledges, the priority of the initialization request, the counter bound and its restart on a dominant strobe, the rule that NORMAL is reached only from a completed run, and the registered interrupt gating. Other behaviours depend on how a sequence unfolds, and only the bench scenarios can show them. These include the exact edge on which an interrupted run finally completes, the path from sleep through synchronization back to NORMAL, and the initialization acknowledge being kept or dropped depending on where SYNC_WAIT was entered from. A behavioural model in the bench compares every output on every clock, across both directed and pseudo-random stimulus.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [2:0] {
        MODE_RESET_INIT = 3'd0,
        MODE_INIT       = 3'd1,
        MODE_SYNC_WAIT  = 3'd2,
        MODE_NORMAL     = 3'd3,
        MODE_SLEEP      = 3'd4
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  init_ack;
        logic  sleep_ack;
        logic  synced;
    } mode_regs_t;

endpackage

// File: rtl/can_run_counter.sv
module can_run_counter #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    input  logic rx_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (!rx_i) begin
                cnt_d = '0;
            end else if (cnt_q != LIMIT) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LIMIT);

    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    assert_dominant_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && tick_i && !rx_i) |=> (cnt_q == '0));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  init_req_i,
    input  logic  sleep_req_i,
    input  logic  run_done_i,
    output mode_e mode_o,
    output logic  init_ack_o,
    output logic  sleep_ack_o,
    output logic  synced_o,
    output logic  count_clear_o
);
    mode_regs_t regs_d, regs_q;

    always_comb begin
        mode_e nxt;
        nxt = regs_q.mode;
        unique case (regs_q.mode)
            MODE_RESET_INIT: nxt = MODE_INIT;
            MODE_INIT: begin
                if (init_req_i)       nxt = MODE_INIT;
                else if (sleep_req_i) nxt = MODE_SLEEP;
                else                  nxt = MODE_SYNC_WAIT;
            end
            MODE_SYNC_WAIT: begin
                if (init_req_i)       nxt = MODE_INIT;
                else if (sleep_req_i) nxt = MODE_SLEEP;
                else if (run_done_i)  nxt = MODE_NORMAL;
            end
            MODE_NORMAL: begin
                if (init_req_i)       nxt = MODE_INIT;
                else if (sleep_req_i) nxt = MODE_SLEEP;
            end
            MODE_SLEEP: begin
                if (init_req_i)        nxt = MODE_INIT;
                else if (!sleep_req_i) nxt = MODE_SYNC_WAIT;
            end
            default: nxt = MODE_INIT;
        endcase

        regs_d.mode      = nxt;
        regs_d.sleep_ack = (nxt == MODE_SLEEP);
        regs_d.synced    = (nxt == MODE_NORMAL);
        if (nxt == MODE_INIT || nxt == MODE_RESET_INIT) begin
            regs_d.init_ack = 1'b1;
        end else if (nxt == MODE_SYNC_WAIT && regs_q.mode != MODE_SLEEP) begin
            regs_d.init_ack = regs_q.init_ack;
        end else begin
            regs_d.init_ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.mode      <= MODE_RESET_INIT;
            regs_q.init_ack  <= 1'b1;
            regs_q.sleep_ack <= 1'b0;
            regs_q.synced    <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mode_o        = regs_q.mode;
    assign init_ack_o    = regs_q.init_ack;
    assign sleep_ack_o   = regs_q.sleep_ack;
    assign synced_o      = regs_q.synced;
    assign count_clear_o = (regs_q.mode != MODE_SYNC_WAIT);

    assert_acks_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_ack_o && sleep_ack_o));

    assert_init_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_req_i |=> (mode_o == MODE_INIT && init_ack_o && !sleep_ack_o));

    assert_normal_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_NORMAL) |=> (mode_o != MODE_NORMAL || $past(run_done_i)));

    assert_sleep_exit_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && !init_req_i && !sleep_req_i) |=>
            (mode_o == MODE_SYNC_WAIT && !init_ack_o && !sleep_ack_o));

    assert_reset_to_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RESET_INIT) |=> (mode_o == MODE_INIT));

endmodule

// File: rtl/can_status_irq.sv
module can_status_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    input  logic enable_i,
    output logic irq_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = flag_i & enable_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !irq_o);

    assert_irq_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_i && enable_i) |=> irq_o);

endmodule

// File: rtl/can_mode_ack_ctrl.sv
module can_mode_ack_ctrl
    import can_mode_pkg::*;
#(
    parameter int RUN_LEN = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_req_i,
    input  logic       sleep_req_i,
    input  logic       rx_i,
    input  logic       bit_tick_i,
    input  logic       err_flag_i,
    input  logic       err_irq_en_i,
    output logic       init_ack_o,
    output logic       sleep_ack_o,
    output logic       synced_o,
    output logic [2:0] mode_o,
    output logic       irq_o
);
    mode_e mode_w;
    logic  run_done_w;
    logic  count_clear_w;

    can_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (count_clear_w),
        .tick_i  (bit_tick_i),
        .rx_i    (rx_i),
        .done_o  (run_done_w)
    );

    can_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .init_req_i    (init_req_i),
        .sleep_req_i   (sleep_req_i),
        .run_done_i    (run_done_w),
        .mode_o        (mode_w),
        .init_ack_o    (init_ack_o),
        .sleep_ack_o   (sleep_ack_o),
        .synced_o      (synced_o),
        .count_clear_o (count_clear_w)
    );

    can_status_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_i   (err_flag_i),
        .enable_i (err_irq_en_i),
        .irq_o    (irq_o)
    );

    assign mode_o = mode_w;

    assert_synced_matches_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        synced_o == (mode_o == 3'd3));

endmodule

// File: tb/can_mode_ack_ctrl_test.sv
module can_mode_ack_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_req = 1'b0, sleep_req = 1'b0, rx = 1'b1, tick = 1'b0;
    logic err_flag = 1'b0, err_en = 1'b0;
    logic init_ack, sleep_ack, synced, irq;
    logic [2:0] mode;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference
    int m_mode = 0, m_cnt = 0;
    bit m_ia = 1, m_sa = 0, m_irq = 0;

    always #5 clk = ~clk;

    can_mode_ack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .init_req_i(init_req), .sleep_req_i(sleep_req),
        .rx_i(rx), .bit_tick_i(tick), .err_flag_i(err_flag), .err_irq_en_i(err_en),
        .init_ack_o(init_ack), .sleep_ack_o(sleep_ack), .synced_o(synced),
        .mode_o(mode), .irq_o(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_ia = 1; m_sa = 0; m_irq = 0;
        end else begin
            int nm, nc;
            bit nia;
            nm = m_mode;
            if (m_mode == 0) nm = 1;
            else if (init_req) nm = 1;
            else if (m_mode == 4) nm = sleep_req ? 4 : 2;
            else if (sleep_req) nm = 4;
            else if (m_mode == 1) nm = 2;
            else if (m_mode == 2 && m_cnt >= 11) nm = 3;
            if (m_mode != 2) nc = 0;
            else if (tick && !rx) nc = 0;
            else if (tick) nc = (m_cnt < 11) ? m_cnt + 1 : 11;
            else nc = m_cnt;
            if (nm <= 1) nia = 1;
            else if (nm == 2 && m_mode != 4) nia = m_ia;
            else nia = 0;
            m_sa = (nm == 4);
            m_ia = nia;
            m_irq = err_flag && err_en;
            m_mode = nm;
            m_cnt = nc;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            chk("R2", "mode", int'(mode), m_mode);
            chk("R1", "init_ack", int'(init_ack), int'(m_ia));
            chk("R5", "sleep_ack", int'(sleep_ack), int'(m_sa));
            chk("R4", "synced", int'(synced), int'(m_mode == 3));
            chk("R6", "irq", int'(irq), int'(m_irq));
            chk("R8", "ack overlap", int'(init_ack && sleep_ack), 0);
        end
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bits(input int n, input logic val);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1; rx = val;
            @(negedge clk); tick = 1'b0; rx = 1'b1;
        end
    endtask

    initial begin
        step(3);
        // R2: reset state observed by the per-cycle compare while rst_n is low
        chk("R2", "reset mode", int'(mode), 0);
        chk("R2", "reset init_ack", int'(init_ack), 1);
        rst_n = 1'b1;
        step(1);
        chk("R2", "mode after reset", int'(mode), 1);
        // R1 / R9: hold init, then release into SYNC_WAIT with ack kept
        init_req = 1'b1; bits(4, 1'b1); step(2);
        init_req = 1'b0; step(2);
        chk("R9", "sync wait mode", int'(mode), 2);
        chk("R9", "init_ack held", int'(init_ack), 1);
        // R3: interrupted run, then full run to NORMAL (R4)
        bits(7, 1'b1); bits(1, 1'b0); bits(10, 1'b1);
        chk("R3", "still waiting", int'(mode), 2);
        bits(1, 1'b1); step(1);
        chk("R4", "normal", int'(mode), 3);
        chk("R4", "init_ack dropped", int'(init_ack), 0);
        // R3: strobes in NORMAL ignored
        bits(5, 1'b0); chk("R3", "normal kept", int'(mode), 3);
        // R5: sleep and wake through sync
        sleep_req = 1'b1; step(2);
        chk("R5", "sleep", int'(mode), 4);
        chk("R5", "sleep_ack", int'(sleep_ack), 1);
        bits(12, 1'b1); chk("R3", "sleep ignores strobes", int'(mode), 4);
        sleep_req = 1'b0; step(2);
        chk("R5", "wake sync", int'(mode), 2);
        chk("R5", "init_ack low on wake", int'(init_ack), 0);
        bits(11, 1'b1); step(1);
        chk("R4", "normal after wake", int'(mode), 3);
        // R7: both requests
        init_req = 1'b1; sleep_req = 1'b1; step(2);
        chk("R7", "init wins", int'(mode), 1);
        chk("R7", "no sleep ack", int'(sleep_ack), 0);
        init_req = 1'b0; step(2);
        chk("R5", "init to sleep", int'(mode), 4);
        sleep_req = 1'b0;
        // R6: interrupt gating
        err_flag = 1'b1; step(3);
        chk("R6", "gated off", int'(irq), 0);
        err_en = 1'b1; step(2);
        chk("R6", "raised", int'(irq), 1);
        err_flag = 1'b0; step(2);
        // pseudo-random phase, model compared every clock
        for (int k = 0; k < 6000; k++) begin
            int r;
            @(negedge clk);
            r = int'($urandom_range(0, 999));
            tick = (r % 3) == 0;
            rx = (r % 29) != 0;
            if (r < 6) init_req = ~init_req;
            else if (r < 12) sleep_req = ~sleep_req;
            err_flag = (r % 7) == 0;
            err_en = (r % 11) != 0;
        end
        step(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule